// File: doc/BRIEF.md
# Card Host Interrupt and DMA Request Router

This block collects the event flags of a memory-card host controller into one request register and combines it with a software mask. From that it drives a single processor interrupt line and two DMA request lines, one for receive and one for transmit. When DMA mode is selected, the two FIFO service requests no longer reach the processor interrupt. They go only to the DMA request lines, whatever the mask holds.

The block also owns the card-clock run/halt control. A start write enables the clock and withdraws the clock-off request. A halt write disables the clock, raises the clock-off request and sends an abort pulse to the transfer engine. A start write also launches a command that is waiting. A command waits from the moment the command setting is written, unless the setting asks to hold the transfer. The clock divider and the card-side interface live elsewhere.

Top module: `mmc_irq_router`

## Requirements
- R1: After reset, irq_o, rx_dma_o, tx_dma_o, clk_en_o, cmd_launch_o, xfer_abort_o and every bit of req_o are 0.
- R2: req_o holds 13 request flags, cleared by reset. The bit positions are: 0 data done, 1 program done, 2 end of command, 3 stop command, 4 clock off, 5 receive FIFO service, 6 transmit FIFO service, 7 timing interrupt, 8 data error, 9 response error, 10 read stalled, 11 card interrupt, 12 card acknowledge. On each clock edge, a bit with evt_clr_i high is cleared and a bit with evt_set_i high is set. Set wins over clear. Bit 4 is also driven by the clock control (R7, R8), which overrides the event inputs.
- R3: A mask write keeps only bits 12:0 of mask_wdata_i. A set mask bit keeps the matching request away from irq_o.
- R4: irq_o is registered. In each cycle it equals the OR, over all 13 bits, of a request bit ANDed with its inverted effective mask bit, taken from the state of the previous cycle.
- R5: While the stored DMA-enable bit (cfg_wdata_i bit 7 at the last setting write) is 1, requests 5 and 6 are treated as masked for irq_o.
- R6: rx_dma_o equals DMA-enable AND request 5, and tx_dma_o equals DMA-enable AND request 6, both one cycle late. Both are 0 while DMA-enable is 0.
- R7: A clock control write with bit 1 set and bit 0 clear sets clk_en_o and clears request 4 at the next edge.
- R8: A clock control write with bit 0 set clears clk_en_o and sets request 4. It also pulses xfer_abort_o high for exactly one cycle.
- R9: If a clock control write has both bits set, the halt wins. The clock ends disabled, request 4 ends set, and no command is launched.
- R10: A setting write marks a command pending. A start write (R7) pulses cmd_launch_o for one cycle and clears the pending mark, but only when a command is pending and the stored hold-transfer bit (cfg_wdata_i bit 10) is 0. Otherwise the pending mark is kept and no launch occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 32 | Mask write data (bits 12:0 kept) |
| clk_ctrl_we_i | input | 1 | Clock control write strobe |
| clk_ctrl_wdata_i | input | 2 | Bit 1 start, bit 0 halt |
| cfg_we_i | input | 1 | Command setting write strobe |
| cfg_wdata_i | input | 14 | Command setting; bit 7 DMA enable, bit 10 hold transfer |
| evt_set_i | input | 13 | Per-request set pulses from the engines |
| evt_clr_i | input | 13 | Per-request clear pulses from the engines |
| irq_o | output | 1 | Processor interrupt |
| rx_dma_o | output | 1 | Receive DMA request |
| tx_dma_o | output | 1 | Transmit DMA request |
| clk_en_o | output | 1 | Card clock enabled status |
| cmd_launch_o | output | 1 | One-cycle command launch pulse |
| xfer_abort_o | output | 1 | One-cycle transfer abort pulse |
| req_o | output | 13 | Request register |

## Verification
The assertions assume that all inputs are synchronous to clk_i and stable around the rising edge. They also assume that clk_ctrl_wdata_i, evt_set_i and evt_clr_i are read only on the cycles they are sampled. The properties that relate request bit 4 to the event inputs exclude that bit, because the clock control may override it. The bench changes every input only at the falling edge. It draws strobes and sparse event vectors from a seeded generator, so halt, start and setting writes often collide with one another and with events on bit 4. Directed cycles cover the double-bit clock write and writes of upper mask bits.

// File: rtl/mmc_irq_pkg.sv
package mmc_irq_pkg;
  localparam int unsigned NUM_SRC      = 13;
  localparam int unsigned CFG_W        = 14;
  localparam int unsigned SRC_DATA_END = 0;
  localparam int unsigned SRC_PRG_END  = 1;
  localparam int unsigned SRC_CMD_END  = 2;
  localparam int unsigned SRC_STOP     = 3;
  localparam int unsigned SRC_CLK_OFF  = 4;
  localparam int unsigned SRC_RX_SVC   = 5;
  localparam int unsigned SRC_TX_SVC   = 6;
  localparam int unsigned CFG_DMA_BIT  = 7;
  localparam int unsigned CFG_HOLD_BIT = 10;
  localparam int unsigned CK_HALT_BIT  = 0;
  localparam int unsigned CK_START_BIT = 1;

  typedef struct packed {
    logic dma_en;
    logic hold;
  } cfg_t;
endpackage

// File: rtl/mmc_irq_req_reg.sv
module mmc_irq_req_reg #(
  parameter int unsigned N = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] force_set_i,
  input  logic [N-1:0] force_clr_i,
  output logic [N-1:0] req_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q <= 1'b0;
      else if (force_set_i[g])    q <= 1'b1;
      else if (force_clr_i[g])    q <= 1'b0;
      else if (set_i[g])          q <= 1'b1;
      else if (clr_i[g])          q <= 1'b0;
    end
    assign req_o[g] = q;
  end
endmodule

// File: rtl/mmc_clk_ctrl.sv
module mmc_clk_ctrl
  import mmc_irq_pkg::*;
#(
  parameter int unsigned N = NUM_SRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [1:0]   wdata_i,
  input  logic         cfg_we_i,
  input  logic         hold_q_i,
  output logic [N-1:0] force_set_o,
  output logic [N-1:0] force_clr_o,
  output logic         clk_en_o,
  output logic         launch_o,
  output logic         abort_o
);
  logic halt, start, pend_q, launch_now;

  assign halt       = we_i & wdata_i[CK_HALT_BIT];
  assign start      = we_i & wdata_i[CK_START_BIT] & ~halt;
  assign launch_now = start & pend_q & ~hold_q_i;

  always_comb begin
    force_set_o = '0;
    force_clr_o = '0;
    force_set_o[SRC_CLK_OFF] = halt;
    force_clr_o[SRC_CLK_OFF] = start;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_en_o <= 1'b0;
      pend_q   <= 1'b0;
      launch_o <= 1'b0;
      abort_o  <= 1'b0;
    end else begin
      if (halt)       clk_en_o <= 1'b0;
      else if (start) clk_en_o <= 1'b1;
      if (cfg_we_i)        pend_q <= 1'b1;
      else if (launch_now) pend_q <= 1'b0;
      launch_o <= launch_now;
      abort_o  <= halt;
    end
  end
endmodule

// File: rtl/mmc_irq_route.sv
module mmc_irq_route
  import mmc_irq_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          mask_we_i,
  input  logic [DW-1:0] mask_wdata_i,
  input  logic          dma_en_i,
  output logic [N-1:0]  mask_o,
  output logic          irq_o,
  output logic          rx_dma_o,
  output logic          tx_dma_o
);
  logic [N-1:0] dma_steer, eff_mask;

  always_comb begin
    dma_steer = '0;
    dma_steer[SRC_RX_SVC] = dma_en_i;
    dma_steer[SRC_TX_SVC] = dma_en_i;
  end
  assign eff_mask = mask_o | dma_steer;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o   <= '0;
      irq_o    <= 1'b0;
      rx_dma_o <= 1'b0;
      tx_dma_o <= 1'b0;
    end else begin
      if (mask_we_i) mask_o <= mask_wdata_i[N-1:0];
      irq_o    <= |(req_i & ~eff_mask);
      rx_dma_o <= dma_en_i & req_i[SRC_RX_SVC];
      tx_dma_o <= dma_en_i & req_i[SRC_TX_SVC];
    end
  end
endmodule

// File: rtl/mmc_irq_router.sv
module mmc_irq_router
  import mmc_irq_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = CFG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mask_we_i,
  input  logic [DW-1:0] mask_wdata_i,
  input  logic          clk_ctrl_we_i,
  input  logic [1:0]    clk_ctrl_wdata_i,
  input  logic          cfg_we_i,
  input  logic [CW-1:0] cfg_wdata_i,
  input  logic [N-1:0]  evt_set_i,
  input  logic [N-1:0]  evt_clr_i,
  output logic          irq_o,
  output logic          rx_dma_o,
  output logic          tx_dma_o,
  output logic          clk_en_o,
  output logic          cmd_launch_o,
  output logic          xfer_abort_o,
  output logic [N-1:0]  req_o
);
  cfg_t         cfg_q;
  logic [N-1:0] force_set, force_clr, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (cfg_we_i) begin
      cfg_q.dma_en <= cfg_wdata_i[CFG_DMA_BIT];
      cfg_q.hold   <= cfg_wdata_i[CFG_HOLD_BIT];
    end
  end

  mmc_clk_ctrl #(.N(N)) u_clk (
    .clk_i, .rst_ni,
    .we_i(clk_ctrl_we_i), .wdata_i(clk_ctrl_wdata_i),
    .cfg_we_i, .hold_q_i(cfg_q.hold),
    .force_set_o(force_set), .force_clr_o(force_clr),
    .clk_en_o, .launch_o(cmd_launch_o), .abort_o(xfer_abort_o)
  );

  mmc_irq_req_reg #(.N(N)) u_req (
    .clk_i, .rst_ni,
    .set_i(evt_set_i), .clr_i(evt_clr_i),
    .force_set_i(force_set), .force_clr_i(force_clr),
    .req_o
  );

  mmc_irq_route #(.N(N), .DW(DW)) u_route (
    .clk_i, .rst_ni,
    .req_i(req_o), .mask_we_i, .mask_wdata_i,
    .dma_en_i(cfg_q.dma_en), .mask_o(mask_q),
    .irq_o, .rx_dma_o, .tx_dma_o
  );
endmodule

// File: rtl/mmc_irq_router_chk.sv
module mmc_irq_router_chk
  import mmc_irq_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clk_ctrl_we_i,
  input logic [1:0]    clk_ctrl_wdata_i,
  input logic [12:0]   evt_set_i,
  input logic [12:0]   mask_q,
  input logic          dma_en,
  input logic          irq_o,
  input logic          rx_dma_o,
  input logic          tx_dma_o,
  input logic          clk_en_o,
  input logic          cmd_launch_o,
  input logic          xfer_abort_o,
  input logic [12:0]   req_o
);
  logic [12:0] chk_mask;
  assign chk_mask = mask_q | (dma_en ? 13'h0060 : 13'h0000);

  a_r9_halt_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_ctrl_we_i && clk_ctrl_wdata_i[0] |=> !clk_en_o && !cmd_launch_o && req_o[4]);
  a_r7_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_ctrl_we_i && clk_ctrl_wdata_i[1] && !clk_ctrl_wdata_i[0] |=> clk_en_o && !req_o[4]);
  a_r8_abort_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_ctrl_we_i && clk_ctrl_wdata_i[0] |=> xfer_abort_o);
  a_r10_launch_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_launch_o |-> clk_en_o);
  a_r2_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |evt_set_i |=> (($past(evt_set_i) & ~13'h0010) & ~req_o) == 13'h0);
  a_r6_rx_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_o |-> $past(req_o[5]) && $past(dma_en));
  a_r6_tx_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dma_o |-> $past(req_o[6]) && $past(dma_en));
  a_r5_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |($past(req_o) & ~$past(chk_mask)));
endmodule

bind mmc_irq_router mmc_irq_router_chk u_chk (
  .clk_i, .rst_ni, .clk_ctrl_we_i, .clk_ctrl_wdata_i, .evt_set_i,
  .mask_q, .dma_en(cfg_q.dma_en),
  .irq_o, .rx_dma_o, .tx_dma_o, .clk_en_o, .cmd_launch_o, .xfer_abort_o, .req_o
);

// File: tb/mmc_irq_router_tb.sv
module mmc_irq_router_tb;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic mask_we_i = 0, clk_ctrl_we_i = 0, cfg_we_i = 0;
  logic [31:0] mask_wdata_i = '0;
  logic [1:0]  clk_ctrl_wdata_i = '0;
  logic [13:0] cfg_wdata_i = '0;
  logic [12:0] evt_set_i = '0, evt_clr_i = '0;
  logic irq_o, rx_dma_o, tx_dma_o, clk_en_o, cmd_launch_o, xfer_abort_o;
  logic [12:0] req_o;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [12:0] m_req, m_mask;
  logic m_dma, m_hold, m_clk, m_pend, m_launch, m_abort;

  always #4 clk_i = ~clk_i;

  mmc_irq_router u_dut (.*);

  function automatic logic f_irq(logic [12:0] rq, logic [12:0] mk, logic dm);
    return |(rq & ~(mk | (dm ? 13'h0060 : 13'h0)));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic mw, logic [31:0] md, logic cw, logic [1:0] cd,
                      logic gw, logic [13:0] gd, logic [12:0] st, logic [12:0] cl,
                      string tag);
    logic halt, start, lnch;
    logic [12:0] nreq;
    logic exp_irq, exp_rx, exp_tx;
    mask_we_i = mw; mask_wdata_i = md; clk_ctrl_we_i = cw; clk_ctrl_wdata_i = cd;
    cfg_we_i = gw; cfg_wdata_i = gd; evt_set_i = st; evt_clr_i = cl;
    exp_irq = f_irq(m_req, m_mask, m_dma);
    exp_rx  = m_dma & m_req[5];
    exp_tx  = m_dma & m_req[6];
    halt  = cw & cd[0];
    start = cw & cd[1] & ~halt;
    lnch  = start & m_pend & ~m_hold;
    nreq  = (m_req & ~cl) | st;
    if (halt) nreq[4] = 1'b1;
    if (start) nreq[4] = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    mask_we_i = 0; clk_ctrl_we_i = 0; cfg_we_i = 0; evt_set_i = '0; evt_clr_i = '0;
    m_req = nreq;
    if (mw) m_mask = md[12:0];
    if (halt) m_clk = 0; else if (start) m_clk = 1;
    if (gw) m_pend = 1; else if (lnch) m_pend = 0;
    if (gw) begin m_dma = gd[7]; m_hold = gd[10]; end
    m_launch = lnch; m_abort = halt;
    chk({"R4/R3/R5 irq ", tag}, irq_o, exp_irq);
    chk({"R6 rx_dma ", tag}, rx_dma_o, exp_rx);
    chk({"R6 tx_dma ", tag}, tx_dma_o, exp_tx);
    chk({"R7/R8/R9 clk_en ", tag}, clk_en_o, m_clk);
    chk({"R2 req ", tag}, req_o, m_req);
    chk({"R10 launch ", tag}, cmd_launch_o, m_launch);
    chk({"R8 abort ", tag}, xfer_abort_o, m_abort);
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    m_req = '0; m_mask = '0; m_dma = 0; m_hold = 0; m_clk = 0; m_pend = 0;
    m_launch = 0; m_abort = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 irq", irq_o, 0); chk("R1 rx", rx_dma_o, 0); chk("R1 tx", tx_dma_o, 0);
    chk("R1 clk_en", clk_en_o, 0); chk("R1 launch", cmd_launch_o, 0);
    chk("R1 abort", xfer_abort_o, 0); chk("R1 req", req_o, 0);

    // R3 upper mask bits dropped: nothing masked, request 0 raises irq
    step(1, 32'hFFFF_E000, 0, 0, 0, 0, 13'h0001, 0, "R3 upper");
    idle("R3 upper irq");
    step(1, 32'h0000_0001, 0, 0, 0, 0, 0, 0, "R3 mask bit0");
    idle("R3 masked");
    // R5/R6 DMA steering
    step(1, 32'h0, 0, 0, 1, 14'h0080, 13'h0060, 13'h0001, "R5 dma on");
    idle("R5 dma irq off");
    idle("R6 dma lines");
    step(0, 0, 0, 0, 1, 14'h0000, 0, 0, "R6 dma off");
    idle("R6 dma off irq");
    step(0, 0, 0, 0, 0, 0, 0, 13'h1FFF, "R2 clear all");
    // R9 both bits: halt wins, pending not launched
    step(0, 0, 1, 2'b11, 0, 0, 0, 0, "R9 both");
    idle("R9 after");
    // R10 start launches pending; hold blocks
    step(0, 0, 1, 2'b10, 0, 0, 0, 0, "R10 start launch");
    idle("R10 pulse end");
    step(0, 0, 0, 0, 1, 14'h0400, 0, 0, "R10 hold cfg");
    step(0, 0, 1, 2'b10, 0, 0, 0, 0, "R10 hold no launch");
    step(0, 0, 1, 2'b01, 1, 14'h0000, 13'h0010, 0, "R8 halt");
    step(0, 0, 1, 2'b10, 0, 0, 13'h0010, 0, "R7 start overrides set");
    idle("R7 after");

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], $urandom,
           r[2] & r[3], r[5:4],
           r[6] & r[7] & r[8], {$urandom} & 14'h3FFF,
           13'($urandom & $urandom & $urandom),
           13'($urandom & $urandom & $urandom), "R4 random");
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule